// File: doc/BRIEF.md
# Fault and Warning Reporting Controller

This block sorts error events from a set of monitor inputs into two classes and reports them. Warnings are report-only. While at least one active warning has not yet been acknowledged, the active-low fault output repeats a pattern of a fixed low phase followed by an equal high phase. Software acknowledges warnings by reading the warning status register, and an acknowledged warning is not reported on the pin again until its condition goes away and returns.

Faults latch. They hold the fault output low and raise a shutdown signal that puts the output stage into high impedance. A fault stays latched until its condition is gone and a clear is requested. A clear comes either from a self-clearing control bit written over the register port or from a rising edge on the gate-enable input. Temperature flags appear only as live status bits. A separate group of faults, for the watchdog and regulator brown-out, is latched and reported on a power-good output instead of the fault pin.

The phase length is `CLK_MHZ * PHASE_US` clock cycles. Register reads are combinational on `rd_addr_i`. A read acknowledges warnings at the clock edge where `rd_en_i` is high, and the effect shows after that edge.

Top module: `fwr_ctrl`

## Requirements
- R1: Under synchronous active-low reset, `nfault_o` is 1, `gate_shutdown_o` is 0, `pwrgd_o` is 1, and the fault (0x2), power-good (0x3) and control (0x9) registers read 0.
- R2: After an edge where a warning rises and no warning was pending, `nfault_o` is 0 for PHASE cycles, then 1 for PHASE cycles, and this repeats while a warning is pending.
- R3: A read with `rd_addr_i`=0x1 acknowledges every pending warning, so `nfault_o` returns to 1 after that edge when no fault is latched. Warning status bits [NUM_WARN-1:0] of register 0x1 still follow the live conditions.
- R4: An acknowledged warning that stays present is not reported again. When it deasserts and reasserts, the pattern restarts. A pending warning whose condition deasserts stops being reported at the next edge.
- R5: Warnings never assert `gate_shutdown_o` and never lower `pwrgd_o`.
- R6: A fault input latches a bit in register 0x2 at its input index, sets the summary bit 10 of register 0x1, holds `nfault_o` at 0 and asserts `gate_shutdown_o`. All of these persist after the input drops.
- R7: A fault takes precedence over a warning, whichever came first: `nfault_o` stays 0 through the warning's high phases and through an acknowledge.
- R8: Writing 0x9 with data bit 1 set makes bit 1 of register 0x9 read 1 for exactly one cycle. At the next edge, latched faults whose inputs are low are cleared.
- R9: A clear while the fault input is still high leaves the fault latched, and the clear bit still returns to 0 after one cycle.
- R10: A rising edge of `gate_en_i` clears latched faults whose inputs are low. A falling edge clears nothing.
- R11: Temperature flags read live at bits [NUM_WARN +: NUM_TEMP] of register 0x1 and never change `nfault_o`.
- R12: A power-good fault latches a bit in register 0x3 and drives `pwrgd_o` to 0 without touching `nfault_o`. It is cleared by the same clear events as R8 and R10.
- R13: A warning rising while another is already pending does not restart the pattern phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| warn_i | input | NUM_WARN | Warning conditions reported on the pin |
| temp_i | input | NUM_TEMP | Temperature flag conditions, status only |
| fault_i | input | NUM_FAULT | Fault conditions that latch and shut down |
| pg_fault_i | input | NUM_PG | Watchdog and regulator brown-out faults |
| gate_en_i | input | 1 | Gate enable; a rising edge clears latched faults |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 16 | Register read data |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 16 | Register write data |
| nfault_o | output | 1 | Fault output, active low (1 = released) |
| gate_shutdown_o | output | 1 | Forces the output stage to high impedance |
| pwrgd_o | output | 1 | Power good, low while a power-good fault is latched |

## Verification
The assertions check, on every cycle, that a low fault pin always has a latched fault or a pending warning behind it. They also check that shutdown and a low power-good each start only after the matching fault input, that a latched fault survives every cycle without a clear event, that the clear bit never lasts two cycles, and that an acknowledge with no competing event releases the pin. The phase lengths, the absence of a restart when a second warning joins (R13), the rearm-after-drop behaviour, precedence across whole phases, and the live temperature bits depend on sequences over many cycles. Only the bench scenarios show those, by comparing the pin and the register contents with values worked out cycle by cycle.

// File: rtl/fwr_pkg.sv
// Shared constants for the fault/warning reporting controller: register
// addresses, data width and fixed bit positions in the register file.
package fwr_pkg;
    localparam int DATA_W        = 16;
    localparam int ADDR_W        = 4;
    localparam logic [ADDR_W-1:0] ADDR_WARN  = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_FAULT = 4'h2;
    localparam logic [ADDR_W-1:0] ADDR_PG    = 4'h3;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'h9;
    localparam int FAULT_SUM_BIT = 10;
    localparam int CLR_BIT       = 1;
endpackage

// File: rtl/fwr_warn_track.sv
// Tracks which warnings are pending on the pin. A warning becomes pending on
// a rising edge of its condition, stops pending when the condition drops or
// when an acknowledge arrives. Assumes inputs are synchronous to clk_i.
module fwr_warn_track #(
    parameter int NUM = 4
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NUM-1:0] warn_i,
    input  logic           ack_i,
    output logic [NUM-1:0] rise_o,
    output logic [NUM-1:0] pend_o,
    output logic           start_o
);
    logic [NUM-1:0] warn_q;

    assign rise_o  = warn_i & ~warn_q;
    // A new pattern starts only if nothing was pending before.
    assign start_o = (|rise_o) && !(|pend_o);

    // Remember the previous condition value for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) warn_q <= '0;
        else         warn_q <= warn_i;
    end

    // Per-source pending flag: a rise sets it, a drop or an ack clears it.
    for (genvar g = 0; g < NUM; g++) begin : g_src
        always_ff @(posedge clk_i) begin
            if (!rst_ni)          pend_o[g] <= 1'b0;
            else if (rise_o[g])   pend_o[g] <= 1'b1;
            else if (ack_i)       pend_o[g] <= 1'b0;
            else                  pend_o[g] <= pend_o[g] & warn_i[g];
        end
    end
endmodule

// File: rtl/fwr_pulse_gen.sv
// Generates the low/high warning pattern. Each phase lasts PHASE_CYCLES
// clocks; the pattern restarts at the low phase on start_i. Assumes
// PHASE_CYCLES >= 2.
module fwr_pulse_gen #(
    parameter int PHASE_CYCLES = 7000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic active_i,
    output logic low_o
);
    localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             low_q;

    assign low_o = low_q;

    // Phase counter and phase flag; idle state parks in the low phase.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            low_q <= 1'b1;
        end else if (start_i) begin
            cnt_q <= '0;
            low_q <= 1'b1;
        end else if (active_i) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                low_q <= ~low_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
            low_q <= 1'b1;
        end
    end
endmodule

// File: rtl/fwr_fault_latch.sv
// Latches a group of fault conditions. A latched bit clears on clear_i only
// when its condition is no longer present; a present condition always sets.
module fwr_fault_latch #(
    parameter int NUM = 4
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NUM-1:0] cond_i,
    input  logic           clear_i,
    output logic [NUM-1:0] lat_o,
    output logic           any_o
);
    assign any_o = |lat_o;

    // Sticky fault bits with a conditional clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) lat_o <= '0;
        else         lat_o <= (lat_o & {NUM{~clear_i}}) | cond_i;
    end
endmodule

// File: rtl/fwr_ctrl.sv
// Top of the fault/warning reporting controller. Combines warning tracking,
// the pattern generator and two fault latches; serves status reads and the
// self-clearing clear-faults control bit. Assumes NUM_WARN + NUM_TEMP <= 10.
module fwr_ctrl
    import fwr_pkg::*;
#(
    parameter int NUM_WARN  = 4,
    parameter int NUM_TEMP  = 4,
    parameter int NUM_FAULT = 4,
    parameter int NUM_PG    = 2,
    parameter int CLK_MHZ   = 125,
    parameter int PHASE_US  = 56
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_WARN-1:0]  warn_i,
    input  logic [NUM_TEMP-1:0]  temp_i,
    input  logic [NUM_FAULT-1:0] fault_i,
    input  logic [NUM_PG-1:0]    pg_fault_i,
    input  logic                 gate_en_i,
    input  logic                 rd_en_i,
    input  logic [3:0]           rd_addr_i,
    output logic [15:0]          rd_data_o,
    input  logic                 wr_en_i,
    input  logic [3:0]           wr_addr_i,
    input  logic [15:0]          wr_data_i,
    output logic                 nfault_o,
    output logic                 gate_shutdown_o,
    output logic                 pwrgd_o
);
    localparam int PHASE_CYCLES = CLK_MHZ * PHASE_US;

    logic [NUM_WARN-1:0]  warn_rise;
    logic [NUM_WARN-1:0]  warn_pend;
    logic                 pend_any;
    logic                 pat_start;
    logic                 pat_low;
    logic                 ack;
    logic                 clr_req;
    logic                 clr_q;
    logic                 gate_en_q;
    logic                 en_rise;
    logic                 clear_evt;
    logic [NUM_FAULT-1:0] flt_lat;
    logic                 flt_any;
    logic [NUM_PG-1:0]    pg_lat;
    logic                 pg_any;

    assign ack       = rd_en_i && (rd_addr_i == ADDR_WARN);
    assign clr_req   = wr_en_i && (wr_addr_i == ADDR_CTRL) && wr_data_i[CLR_BIT];
    assign en_rise   = gate_en_i && !gate_en_q;
    assign clear_evt = clr_q || en_rise;
    assign pend_any  = |warn_pend;

    fwr_warn_track #(.NUM(NUM_WARN)) u_warn (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .warn_i  (warn_i),
        .ack_i   (ack),
        .rise_o  (warn_rise),
        .pend_o  (warn_pend),
        .start_o (pat_start)
    );

    fwr_pulse_gen #(.PHASE_CYCLES(PHASE_CYCLES)) u_pulse (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (pat_start),
        .active_i (pend_any),
        .low_o    (pat_low)
    );

    fwr_fault_latch #(.NUM(NUM_FAULT)) u_flt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cond_i  (fault_i),
        .clear_i (clear_evt),
        .lat_o   (flt_lat),
        .any_o   (flt_any)
    );

    fwr_fault_latch #(.NUM(NUM_PG)) u_pg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cond_i  (pg_fault_i),
        .clear_i (clear_evt),
        .lat_o   (pg_lat),
        .any_o   (pg_any)
    );

    // Clear bit lives one cycle; a held write cannot keep it high.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) clr_q <= 1'b0;
        else         clr_q <= clr_req && !clr_q;
    end

    // Previous gate-enable value for rising-edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) gate_en_q <= 1'b0;
        else         gate_en_q <= gate_en_i;
    end

    // Output pins: a latched fault wins over the warning pattern.
    assign nfault_o        = !(flt_any || (pend_any && pat_low));
    assign gate_shutdown_o = flt_any;
    assign pwrgd_o         = !pg_any;

    // Register read multiplexer.
    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            ADDR_WARN: begin
                rd_data_o[NUM_WARN-1:0]         = warn_i;
                rd_data_o[NUM_WARN +: NUM_TEMP] = temp_i;
                rd_data_o[FAULT_SUM_BIT]        = flt_any;
            end
            ADDR_FAULT: rd_data_o[NUM_FAULT-1:0] = flt_lat;
            ADDR_PG:    rd_data_o[NUM_PG-1:0]    = pg_lat;
            ADDR_CTRL:  rd_data_o[CLR_BIT]       = clr_q;
            default:    rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/fwr_ctrl_chk.sv
// Assertion checker for fwr_ctrl, attached with bind below.
module fwr_ctrl_chk
    import fwr_pkg::*;
#(
    parameter int NUM_WARN  = 4,
    parameter int NUM_FAULT = 4,
    parameter int NUM_PG    = 2
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 nfault_o,
    input logic                 gate_shutdown_o,
    input logic                 pwrgd_o,
    input logic [NUM_FAULT-1:0] fault_i,
    input logic [NUM_PG-1:0]    pg_fault_i,
    input logic [NUM_WARN-1:0]  warn_rise,
    input logic                 pend_any,
    input logic                 clr_q,
    input logic                 en_rise,
    input logic                 rd_en_i,
    input logic [3:0]           rd_addr_i
);
    p_fault_pin_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_shutdown_o |-> !nfault_o);

    p_fault_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_shutdown_o && !clr_q && !en_rise) |=> gate_shutdown_o);

    p_clr_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_q |=> !clr_q);

    p_shutdown_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_shutdown_o) |-> $past(|fault_i));

    p_pg_cause_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pwrgd_o) |-> $past(|pg_fault_i));

    p_pin_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !nfault_o |-> (gate_shutdown_o || pend_any));

    p_ack_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && rd_addr_i == ADDR_WARN && !(|warn_rise) && !gate_shutdown_o
         && !(|fault_i)) |=> nfault_o);
endmodule

bind fwr_ctrl fwr_ctrl_chk #(
    .NUM_WARN  (NUM_WARN),
    .NUM_FAULT (NUM_FAULT),
    .NUM_PG    (NUM_PG)
) i_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .nfault_o        (nfault_o),
    .gate_shutdown_o (gate_shutdown_o),
    .pwrgd_o         (pwrgd_o),
    .fault_i         (fault_i),
    .pg_fault_i      (pg_fault_i),
    .warn_rise       (warn_rise),
    .pend_any        (pend_any),
    .clr_q           (clr_q),
    .en_rise         (en_rise),
    .rd_en_i         (rd_en_i),
    .rd_addr_i       (rd_addr_i)
);

// File: tb/test_fwr_ctrl.sv
`timescale 1ns/1ps
module test_fwr_ctrl;
    // Phase of 3 cycles: CLK_MHZ=1, PHASE_US=3.
    localparam int PH = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  warn, temp, flt;
    logic [1:0]  pg;
    logic        gen, rd_en, wr_en;
    logic [3:0]  rd_addr, wr_addr;
    logic [15:0] wr_data, rd_data;
    logic        nf, sd, pgd;
    int          n_tests = 0;
    int          n_fail  = 0;

    always #4 clk = ~clk;

    fwr_ctrl #(.CLK_MHZ(1), .PHASE_US(PH)) i_fwr_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .warn_i(warn), .temp_i(temp),
        .fault_i(flt), .pg_fault_i(pg), .gate_en_i(gen),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .nfault_o(nf), .gate_shutdown_o(sd), .pwrgd_o(pgd)
    );

    typedef struct packed {
        logic [3:0]  w;
        logic [3:0]  t;
        logic [3:0]  f;
        logic [1:0]  p;
        logic        rd;
        logic [3:0]  addr;
        logic        clr;
        logic        ge;
        logic        e_nf;
        logic        e_sd;
        logic        e_pg;
        logic        chk;
        logic [15:0] e_rd;
        logic [7:0]  req;
    } vec_t;

    // Rows: inputs for one cycle, outputs expected just after that edge.
    localparam vec_t VECS [39] = '{
        '{4'h0,4'h0,4'h0,2'd0,1'b1,4'h1,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b1,16'h0000, 8'd1},  // R1
        '{4'h1,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b0,1'b1, 1'b0,16'h0000, 8'd2},  // R2
        '{4'h1,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b0,1'b1, 1'b0,16'h0000, 8'd2},
        '{4'h1,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b0,1'b1, 1'b0,16'h0000, 8'd2},
        '{4'h1,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b0,16'h0000, 8'd2},
        '{4'h1,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b0,16'h0000, 8'd2},
        '{4'h3,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b0,16'h0000, 8'd13}, // R13
        '{4'h3,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b0,1'b1, 1'b0,16'h0000, 8'd13},
        '{4'h3,4'h0,4'h0,2'd0,1'b1,4'h1,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b1,16'h0003, 8'd3},  // R3
        '{4'h3,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b0,16'h0000, 8'd4},  // R4
        '{4'h2,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b0,16'h0000, 8'd4},
        '{4'h3,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b0,1'b1, 1'b0,16'h0000, 8'd4},
        '{4'h3,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b0,1'b1, 1'b0,16'h0000, 8'd4},
        '{4'h3,4'h0,4'h0,2'd0,1'b1,4'h1,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b0,16'h0000, 8'd5},  // R5
        '{4'h0,4'hA,4'h0,2'd0,1'b1,4'h1,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b1,16'h00A0, 8'd11}, // R11
        '{4'h0,4'hA,4'h4,2'd0,1'b1,4'h2,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b1,16'h0004, 8'd6},  // R6
        '{4'h0,4'h0,4'h0,2'd0,1'b1,4'h1,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b1,16'h0400, 8'd6},
        '{4'h1,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b0,16'h0000, 8'd7},  // R7
        '{4'h1,4'h0,4'h0,2'd0,1'b1,4'h9,1'b1,1'b1, 1'b0,1'b1,1'b1, 1'b1,16'h0002, 8'd8},  // R8
        '{4'h1,4'h0,4'h0,2'd0,1'b1,4'h9,1'b0,1'b1, 1'b0,1'b0,1'b1, 1'b1,16'h0000, 8'd8},
        '{4'h1,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b0,16'h0000, 8'd8},
        '{4'h0,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b0,16'h0000, 8'd5},
        '{4'h0,4'h0,4'h1,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b0,16'h0000, 8'd6},
        '{4'h0,4'h0,4'h1,2'd0,1'b0,4'h0,1'b1,1'b1, 1'b0,1'b1,1'b1, 1'b0,16'h0000, 8'd9},  // R9
        '{4'h0,4'h0,4'h1,2'd0,1'b1,4'h9,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b1,16'h0000, 8'd9},
        '{4'h0,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b0,16'h0000, 8'd6},
        '{4'h0,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b0, 1'b0,1'b1,1'b1, 1'b0,16'h0000, 8'd10}, // R10
        '{4'h0,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b0,16'h0000, 8'd10},
        '{4'h0,4'h0,4'h0,2'd1,1'b1,4'h3,1'b0,1'b1, 1'b1,1'b0,1'b0, 1'b1,16'h0001, 8'd12}, // R12
        '{4'h0,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,1'b0, 1'b0,16'h0000, 8'd12},
        '{4'h0,4'h0,4'h0,2'd0,1'b0,4'h0,1'b1,1'b1, 1'b1,1'b0,1'b0, 1'b0,16'h0000, 8'd12},
        '{4'h0,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b0,16'h0000, 8'd12},
        '{4'h4,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b0,1'b1, 1'b0,16'h0000, 8'd2},
        '{4'h4,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b0,1'b1, 1'b0,16'h0000, 8'd2},
        '{4'h4,4'h0,4'h8,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b0,16'h0000, 8'd7},
        '{4'h4,4'h0,4'h0,2'd0,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b0,16'h0000, 8'd7},
        '{4'h4,4'h0,4'h0,2'd0,1'b1,4'h1,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b1,16'h0404, 8'd7},
        '{4'h0,4'h0,4'h0,2'd0,1'b0,4'h0,1'b1,1'b1, 1'b0,1'b1,1'b1, 1'b0,16'h0000, 8'd8},
        '{4'h0,4'h0,4'h0,2'd0,1'b1,4'h2,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b1,16'h0000, 8'd8}
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] w, input logic [3:0] t, input logic [3:0] f,
                         input logic [1:0] p, input logic rd, input logic [3:0] a,
                         input logic clr, input logic ge);
        warn = w; temp = t; flt = f; pg = p; gen = ge;
        rd_en = rd; rd_addr = a;
        wr_en = clr; wr_addr = 4'h9; wr_data = clr ? 16'h0002 : 16'h0000;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(4'h0, 4'h0, 4'h0, 2'd0, 1'b0, 4'h2, 1'b0, 1'b1);
        repeat (3) @(posedge clk);
        #1;
        check("R1", "nfault in reset", {15'd0, nf}, 16'd1);
        check("R1", "shutdown in reset", {15'd0, sd}, 16'd0);
        check("R1", "pwrgd in reset", {15'd0, pgd}, 16'd1);
        check("R1", "fault reg in reset", rd_data, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < 39; i++) begin
            string rq;
            @(negedge clk);
            drive(VECS[i].w, VECS[i].t, VECS[i].f, VECS[i].p, VECS[i].rd,
                  VECS[i].addr, VECS[i].clr, VECS[i].ge);
            @(posedge clk);
            #1;
            rq = $sformatf("R%0d row %0d", VECS[i].req, i);
            check(rq, "nfault", {15'd0, nf}, {15'd0, VECS[i].e_nf});
            check(rq, "shutdown", {15'd0, sd}, {15'd0, VECS[i].e_sd});
            check(rq, "pwrgd", {15'd0, pgd}, {15'd0, VECS[i].e_pg});
            if (VECS[i].chk) check(rq, "rd_data", rd_data, VECS[i].e_rd);
        end

        // R2: several full periods of the pattern from a fresh start.
        for (int k = 0; k < 4 * PH; k++) begin
            @(negedge clk);
            drive(4'h1, 4'h0, 4'h0, 2'd0, 1'b0, 4'h0, 1'b0, 1'b1);
            @(posedge clk);
            #1;
            check("R2", "pattern", {15'd0, nf}, {15'd0, ((k / PH) % 2) != 0});
        end
        @(negedge clk);
        drive(4'h0, 4'h0, 4'h0, 2'd0, 1'b0, 4'h0, 1'b0, 1'b1);
        @(posedge clk);
        #1;
        check("R4", "idle after drop", {15'd0, nf}, 16'd1);

        // R4: an unacknowledged warning that drops in its low phase releases the pin.
        @(negedge clk);
        drive(4'h2, 4'h0, 4'h0, 2'd0, 1'b0, 4'h0, 1'b0, 1'b1);
        @(posedge clk);
        #1;
        check("R4", "new warning low", {15'd0, nf}, 16'd0);
        @(negedge clk);
        drive(4'h0, 4'h0, 4'h0, 2'd0, 1'b0, 4'h0, 1'b0, 1'b1);
        @(posedge clk);
        #1;
        check("R4", "drop releases", {15'd0, nf}, 16'd1);

        // R11: temperature flags are live and never move the pin.
        for (int k = 0; k < 5; k++) begin
            logic [3:0] tv;
            tv = 4'(k * 5 + 3);
            @(negedge clk);
            drive(4'h0, tv, 4'h0, 2'd0, 1'b1, 4'h1, 1'b0, 1'b1);
            @(posedge clk);
            #1;
            check("R11", "temp live", rd_data, {8'h00, tv, 4'h0});
            check("R11", "temp pin", {15'd0, nf}, 16'd1);
        end

        // R1: reset while a fault is latched returns to the idle state.
        @(negedge clk);
        drive(4'h0, 4'h0, 4'h1, 2'd2, 1'b0, 4'h2, 1'b0, 1'b1);
        @(negedge clk);
        drive(4'h0, 4'h0, 4'h0, 2'd0, 1'b0, 4'h2, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "reset clears fault reg", rd_data, 16'h0000);
        check("R1", "reset nfault", {15'd0, nf}, 16'd1);
        check("R1", "reset shutdown", {15'd0, sd}, 16'd0);
        check("R1", "reset pwrgd", {15'd0, pgd}, 16'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule